// File: doc/BRIEF.md
# Cascadable LCD Segment Column Driver

This block is the digital core of a segment-side driver for a dot-matrix LCD panel with 80 columns. A controller pushes one display line into it through a shift strobe. Each falling edge carries either one bit on the serial pin, or a 4-bit nibble made of the serial pin plus three parallel pins. An internal position counter places each write into a fill latch. A falling edge on a load strobe copies the whole fill latch into a display latch in one step. Each column then presents a 2-bit drive-level code. The code is built from its display bit, the frame alternation phase and a blanking input.

Several drivers form a wider row by chaining a chip-disable signal. A driver accepts writes only while its disable input is low. Once its last position has been written, it pulls its disable output low, which hands the write enable on to the next driver. The load strobe rearms every driver in the chain at once.

All strobes are treated as level inputs that are already synchronous to the block clock. Their falling edges are found by comparing each strobe with its value on the previous clock.

Top module: `seg_column_driver`

## Requirements
- R1: After reset, `cd_out` is 1 and every column holds display bit 0. With `m_phase`=0 and `disp_off`=0, every 2-bit column code therefore reads 00.
- R2: When `par_mode`=0, each accepted falling edge of `shift_clk` stores `sdi` into the column named by the position counter, and the counter then advances by one. The first bit after a load goes to column 0.
- R3: When `par_mode`=1, each accepted falling edge stores the nibble {`pdi[2:0]`,`sdi`} into nibble slot n, and the counter advances by one slot. Bit k of the nibble goes to column 4n+k, so `sdi` lands in column 4n. The mode is held constant for a whole line.
- R4: While `cd_in` is 1, falling edges of `shift_clk` change neither the fill latch nor the position counter.
- R5: Writing the last position (column 79 in serial mode, slot 19 in parallel mode) drives `cd_out` to 0 on the next clock. After that, further shift edges are ignored until a load.
- R6: A falling edge of `load_strb` copies the fill latch into the display latch, resets the counter to position 0 and drives `cd_out` to 1. The fill latch keeps its contents.
- R7: When falling edges of `load_strb` and `shift_clk` are seen on the same clock, the load takes effect and that write is dropped.
- R8: Column c drives `col_lvl[2c+1:2c]` = {sel, `m_phase`}, where sel is the column's display bit. The codes are: 00 = V3, 01 = V4 (these two are the non-selected levels), 10 = VEE, 11 = V1 (these two are the selected levels).
- R9: While `disp_off`=1, sel is 0 for every column, so each column shows the non-selected level of the current phase. The display latch is unchanged, and the data reappears as soon as `disp_off` returns to 0.
- R10: Between loads, the column codes depend only on the display latch, `m_phase` and `disp_off`. Writes into the fill latch do not alter them.
- R11: Only a falling edge of `shift_clk` writes. Holding `shift_clk` low for many clocks performs exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| par_mode | input | 1 | 1 = nibble writes, 0 = single-bit writes |
| shift_clk | input | 1 | Data strobe, acts on its falling edge |
| load_strb | input | 1 | Line transfer strobe, acts on its falling edge |
| cd_in | input | 1 | Chip-disable input from the previous driver (low = accept) |
| sdi | input | 1 | Serial data, also nibble bit 0 |
| pdi | input | 3 | Nibble bits 3..1 in parallel mode |
| m_phase | input | 1 | Frame alternation phase |
| disp_off | input | 1 | Blank all columns to the non-selected level |
| cd_out | output | 1 | Chip-disable output to the next driver (low = line full here) |
| col_lvl | output | 160 | Two-bit drive code per column, column c at bits 2c+1:2c |

## Verification
Several properties are checked on every cycle:
- a high `cd_in` leaves the fill latch untouched;
- `cd_out` rises only after a load and falls only after a write;
- a load copies the fill latch exactly;
- the display latch holds between loads;
- blanking removes every selected level;
- the counter stays in range.

The bench scenarios are needed for the rest. Correct placement of serial bits and nibble bits, counter rollover at the last position, load-over-shift priority, single writes from a held-low strobe, and cascade handoff are only visible across a full line followed by a load.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;

  // Drive level code: {selected, phase}
  typedef enum logic [1:0] {
    LVL_V3  = 2'b00,
    LVL_V4  = 2'b01,
    LVL_VEE = 2'b10,
    LVL_V1  = 2'b11
  } drv_lvl_e;

  localparam int LVL_W = 2;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/seg_fill_ctrl.sv
module seg_fill_ctrl #(
  parameter int NUM_COLS = 80,
  parameter int NIB_W    = 4,
  localparam int NUM_NIBS = NUM_COLS / NIB_W,
  localparam int ADDR_W   = $clog2(NUM_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_mode,
  input  logic              shift_clk,
  input  logic              load_strb,
  input  logic              cd_in,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              ld_stb,
  output logic              cd_out
);

  localparam logic [ADDR_W-1:0] LAST_SER = ADDR_W'(NUM_COLS - 1);
  localparam logic [ADDR_W-1:0] LAST_PAR = ADDR_W'(NUM_NIBS - 1);

  logic              shift_prev_q, load_prev_q;
  logic              shift_fall, load_fall;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              cdo_q, cdo_d;
  logic              ctl_en;
  logic [ADDR_W-1:0] last_pos;

  // edge detection (strobes idle high)
  assign shift_fall = shift_prev_q & ~shift_clk;
  assign load_fall  = load_prev_q & ~load_strb;

  assign last_pos = par_mode ? LAST_PAR : LAST_SER;

  // accept: enabled by chain, not yet full, load has priority
  assign wr_stb = shift_fall & ~cd_in & cdo_q & ~load_fall;
  assign ctl_en = load_fall | wr_stb;

  always_comb begin
    addr_d = addr_q;
    cdo_d  = cdo_q;
    if (load_fall) begin
      addr_d = '0;
      cdo_d  = 1'b1;
    end else if (wr_stb) begin
      if (addr_q == last_pos) begin
        addr_d = '0;
        cdo_d  = 1'b0;
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_prev_q <= 1'b1;
      load_prev_q  <= 1'b1;
    end else begin
      shift_prev_q <= shift_clk;
      load_prev_q  <= load_strb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cdo_q  <= 1'b1;
    end else if (ctl_en) begin
      addr_q <= addr_d;
      cdo_q  <= cdo_d;
    end
  end

  assign wr_addr = addr_q;
  assign ld_stb  = load_fall;
  assign cd_out  = cdo_q;

endmodule

// File: rtl/seg_line_store.sv
module seg_line_store #(
  parameter int NUM_COLS = 80,
  parameter int NIB_W    = 4,
  localparam int ADDR_W  = $clog2(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                par_mode,
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic                sdi,
  input  logic [NIB_W-2:0]    pdi,
  input  logic                ld_stb,
  output logic [NUM_COLS-1:0] fill_q,
  output logic [NUM_COLS-1:0] disp_q
);

  logic [NIB_W-1:0]    nib;
  logic [NUM_COLS-1:0] col_we, col_din;
  logic [NUM_COLS-1:0] fill_d;

  assign nib = {pdi, sdi};

  // per-column address decode
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    localparam int NIB_IDX = c / NIB_W;
    localparam int BIT_IDX = c % NIB_W;
    logic hit;
    assign hit        = par_mode ? (wr_addr == ADDR_W'(NIB_IDX))
                                 : (wr_addr == ADDR_W'(c));
    assign col_we[c]  = wr_stb & hit;
    assign col_din[c] = par_mode ? nib[BIT_IDX] : sdi;
  end

  always_comb begin
    for (int c = 0; c < NUM_COLS; c++) begin
      fill_d[c] = col_we[c] ? col_din[c] : fill_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (wr_stb) begin
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= '0;
    end else if (ld_stb) begin
      disp_q <= fill_q;
    end
  end

endmodule

// File: rtl/seg_level_map.sv
module seg_level_map
  import seg_drv_pkg::*;
#(
  parameter int NUM_COLS = 80
) (
  input  logic                      m_phase,
  input  logic                      disp_off,
  input  logic [NUM_COLS-1:0]       disp_q,
  output logic [LVL_W*NUM_COLS-1:0] col_lvl
);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_map
    logic     sel;
    drv_lvl_e lvl;
    assign sel = disp_q[c] & ~disp_off;
    always_comb begin
      case ({sel, m_phase})
        2'b00:   lvl = LVL_V3;
        2'b01:   lvl = LVL_V4;
        2'b10:   lvl = LVL_VEE;
        default: lvl = LVL_V1;
      endcase
    end
    assign col_lvl[LVL_W*c +: LVL_W] = lvl;
  end

endmodule

// File: rtl/seg_column_driver.sv
module seg_column_driver
  import seg_drv_pkg::*;
#(
  parameter int NUM_COLS = 80,
  parameter int NIB_W    = 4,
  localparam int ADDR_W  = $clog2(NUM_COLS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      par_mode,
  input  logic                      shift_clk,
  input  logic                      load_strb,
  input  logic                      cd_in,
  input  logic                      sdi,
  input  logic [NIB_W-2:0]          pdi,
  input  logic                      m_phase,
  input  logic                      disp_off,
  output logic                      cd_out,
  output logic [LVL_W*NUM_COLS-1:0] col_lvl
);

  logic                rst_n_i;
  logic                wr_stb, ld_stb;
  logic [ADDR_W-1:0]   wr_addr;
  logic [NUM_COLS-1:0] fill_q, disp_q;

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_i)
  );

  seg_fill_ctrl #(.NUM_COLS(NUM_COLS), .NIB_W(NIB_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .par_mode(par_mode),
    .shift_clk(shift_clk), .load_strb(load_strb), .cd_in(cd_in),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .ld_stb(ld_stb), .cd_out(cd_out)
  );

  seg_line_store #(.NUM_COLS(NUM_COLS), .NIB_W(NIB_W)) u_store (
    .clk(clk), .rst_n(rst_n_i), .par_mode(par_mode),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .sdi(sdi), .pdi(pdi),
    .ld_stb(ld_stb), .fill_q(fill_q), .disp_q(disp_q)
  );

  seg_level_map #(.NUM_COLS(NUM_COLS)) u_map (
    .m_phase(m_phase), .disp_off(disp_off), .disp_q(disp_q), .col_lvl(col_lvl)
  );

endmodule

// File: rtl/seg_column_driver_chk.sv
module seg_column_driver_chk #(
  parameter int NUM_COLS = 80,
  localparam int ADDR_W  = $clog2(NUM_COLS)
) (
  input logic                  clk,
  input logic                  rst_n_i,
  input logic                  cd_in,
  input logic                  cd_out,
  input logic                  disp_off,
  input logic [2*NUM_COLS-1:0] col_lvl,
  input logic                  wr_stb,
  input logic                  ld_stb,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [NUM_COLS-1:0]   fill_q,
  input logic [NUM_COLS-1:0]   disp_q
);

  logic any_sel;
  always_comb begin
    any_sel = 1'b0;
    for (int c = 0; c < NUM_COLS; c++) any_sel = any_sel | col_lvl[2*c+1];
  end

  // R4
  cdi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    cd_in |=> $stable(fill_q));

  // R6
  cdo_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(cd_out) |-> $past(ld_stb));

  // R5
  cdo_full_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(cd_out) |-> $past(wr_stb));

  // R6
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    ld_stb |=> (disp_q == $past(fill_q)));

  // R10
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !ld_stb |=> $stable(disp_q));

  // R9
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    disp_off |-> !any_sel);

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    wr_addr < ADDR_W'(NUM_COLS));

endmodule

bind seg_column_driver seg_column_driver_chk #(.NUM_COLS(NUM_COLS)) u_chk (
  .clk(clk), .rst_n_i(rst_n_i), .cd_in(cd_in), .cd_out(cd_out),
  .disp_off(disp_off), .col_lvl(col_lvl), .wr_stb(wr_stb), .ld_stb(ld_stb),
  .wr_addr(wr_addr), .fill_q(fill_q), .disp_q(disp_q)
);

// File: tb/tb_seg_column_driver.sv
module tb_seg_column_driver;

  localparam int NC = 80;

  logic          clk, rst_n, par_mode, shift_clk, load_strb, cd_in, sdi;
  logic [2:0]    pdi;
  logic          m_phase, disp_off, cd_out;
  logic [2*NC-1:0] col_lvl;

  int checks = 0;
  int errors = 0;

  logic [NC-1:0] fill_m, disp_m;
  int            addr_m;
  logic          cdo_m;

  seg_column_driver dut (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .shift_clk(shift_clk),
    .load_strb(load_strb), .cd_in(cd_in), .sdi(sdi), .pdi(pdi),
    .m_phase(m_phase), .disp_off(disp_off), .cd_out(cd_out), .col_lvl(col_lvl)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  function automatic logic [2*NC-1:0] exp_lvl(input logic [NC-1:0] d,
                                              input logic m, input logic off);
    logic [2*NC-1:0] r;
    for (int c = 0; c < NC; c++) r[2*c +: 2] = {d[c] & ~off, m};
    return r;
  endfunction

  task automatic check_out(input string req);
    logic [2*NC-1:0] e;
    e = exp_lvl(disp_m, m_phase, disp_off);
    checks++;
    if (col_lvl !== e) begin
      errors++;
      $display("FAIL %s col_lvl actual=%h expected=%h", req, col_lvl, e);
    end
    checks++;
    if (cd_out !== cdo_m) begin
      errors++;
      $display("FAIL %s cd_out actual=%b expected=%b", req, cd_out, cdo_m);
    end
  endtask

  task automatic model_write(input logic par, input logic s, input logic [2:0] p);
    logic [3:0] nb;
    nb = {p, s};
    if (par) begin
      for (int k = 0; k < 4; k++) fill_m[4*addr_m + k] = nb[k];
    end else begin
      fill_m[addr_m] = s;
    end
    if (addr_m == (par ? NC/4 - 1 : NC - 1)) begin
      addr_m = 0;
      cdo_m  = 1'b0;
    end else begin
      addr_m++;
    end
  endtask

  task automatic shift_one(input logic par, input logic s,
                           input logic [2:0] p, input logic cdi);
    @(negedge clk);
    par_mode = par; sdi = s; pdi = p; cd_in = cdi; shift_clk = 1'b0;
    if (!cdi && cdo_m) model_write(par, s, p);
    @(negedge clk);
    shift_clk = 1'b1; cd_in = 1'b0;
  endtask

  task automatic load_line();
    @(negedge clk);
    load_strb = 1'b0;
    disp_m = fill_m; addr_m = 0; cdo_m = 1'b1;
    @(negedge clk);
    load_strb = 1'b1;
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; par_mode = 1'b0; shift_clk = 1'b1; load_strb = 1'b1;
    cd_in = 1'b0; sdi = 1'b0; pdi = 3'b000; m_phase = 1'b0; disp_off = 1'b0;
    fill_m = '0; disp_m = '0; addr_m = 0; cdo_m = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out("R1 reset");

    // R2 serial full line, R5 full flag
    for (int i = 0; i < NC; i++) shift_one(1'b0, logic'((i % 3) == 0), 3'b000, 1'b0);
    check_out("R5 full after last serial");
    for (int i = 0; i < 4; i++) shift_one(1'b0, 1'b1, 3'b000, 1'b0);
    check_out("R10 outputs hold before load");
    load_line();
    check_out("R2 R5 serial line loaded");

    // R3 parallel line, R8 with m=1
    m_phase = 1'b1;
    for (int i = 0; i < NC/4; i++) shift_one(1'b1, logic'($urandom_range(1)), 3'($urandom_range(7)), 1'b0);
    check_out("R5 full after last nibble");
    load_line();
    check_out("R3 R8 parallel line m=1");
    m_phase = 1'b0;
    @(negedge clk);
    check_out("R8 phase 0");

    // R4 cd_in high ignored
    for (int i = 0; i < 10; i++) shift_one(1'b0, 1'b1, 3'b000, logic'(i % 2));
    load_line();
    check_out("R4 cd_in blocks writes");

    // R6 fill kept across loads
    load_line();
    check_out("R6 reload keeps fill");

    // R9 blanking
    disp_off = 1'b1;
    @(negedge clk); check_out("R9 blank m=0");
    m_phase = 1'b1;
    @(negedge clk); check_out("R9 blank m=1");
    disp_off = 1'b0;
    @(negedge clk); check_out("R9 data returns");
    m_phase = 1'b0;

    // R7 load and shift same cycle
    shift_one(1'b0, 1'b0, 3'b000, 1'b0);
    @(negedge clk);
    sdi = 1'b1; par_mode = 1'b0; shift_clk = 1'b0; load_strb = 1'b0;
    disp_m = fill_m; addr_m = 0; cdo_m = 1'b1;
    @(negedge clk);
    shift_clk = 1'b1; load_strb = 1'b1;
    shift_one(1'b0, 1'b0, 3'b000, 1'b0);
    load_line();
    check_out("R7 load wins over shift");

    // R11 held-low strobe writes once
    @(negedge clk);
    par_mode = 1'b0; sdi = 1'b1; shift_clk = 1'b0;
    model_write(1'b0, 1'b1, 3'b000);
    repeat (6) @(negedge clk);
    shift_clk = 1'b1;
    shift_one(1'b0, 1'b0, 3'b000, 1'b0);
    load_line();
    check_out("R11 single write per edge");

    // random lines
    for (int ln = 0; ln < 8; ln++) begin
      logic par;
      int   n;
      par = logic'($urandom_range(1));
      n   = $urandom_range(par ? NC/4 + 3 : NC + 5, 1);
      for (int i = 0; i < n; i++)
        shift_one(par, logic'($urandom_range(1)), 3'($urandom_range(7)),
                  logic'($urandom_range(4) == 0));
      check_out("R5 cd_out during random line");
      load_line();
      m_phase  = logic'($urandom_range(1));
      disp_off = logic'($urandom_range(3) == 0);
      @(negedge clk);
      check_out(par ? "R3 R8 random parallel" : "R2 R8 random serial");
      disp_off = 1'b0;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule